// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This purely combinational block chooses, for each of the two source operands, where the operand value comes from. In a five-stage in-order pipeline the operand can come from the register file or be bypassed from a later stage. The block serves two places. The first is the execute stage, where either operand can take the memory-stage ALU result or the writeback-stage result. The second is the decode stage, where either operand can take only the memory-stage ALU result. The decode-stage bypass exists so that a branch can compare its operands early.

A bypass from a stage is chosen only when three things hold: that stage writes a register, its destination register number equals the consumer's source register number, and that source number is not zero. Register zero is hardwired, so it is never bypassed. When both later stages match an execute operand, the memory stage wins because it holds the younger result.

The block also carries the four operand muxes, which a parameter can remove. When they are removed, the block emits only the select codes and drives the operand outputs to zero.

Top module: `operand_bypass_unit`

## Requirements
- R1: Each execute select is two bits: 2'b10 selects the memory-stage ALU result, 2'b01 the writeback-stage result, 2'b00 the register-file read data.
- R2: When the memory and writeback stages both qualify for the same execute operand, the select is 2'b10.
- R3: A stage qualifies only if its write flag is 1 and its destination number equals the operand's source number; otherwise that stage is not selected.
- R4: A source number of zero always yields select 2'b00 (execute) or 1'b0 (decode), whatever the stage flags and destinations are.
- R5: Operand B (rt field) is selected by the same rules as operand A (rs field), evaluated on its own source number and independently of operand A.
- R6: Each decode select is one bit: 1'b1 selects the memory-stage ALU result, 1'b0 the register-file read data.
- R7: The decode select never reflects the writeback stage; a writeback-only match leaves it at 1'b0.
- R8: With the muxes enabled, every operand output equals the value that its select code names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | Decode-stage rs number |
| id_src_b | input | REG_AW | Decode-stage rt number |
| ex_src_a | input | REG_AW | Execute-stage rs number |
| ex_src_b | input | REG_AW | Execute-stage rt number |
| mem_dst | input | REG_AW | Memory-stage destination number |
| mem_wr | input | 1 | Memory-stage register-write flag |
| wb_dst | input | REG_AW | Writeback-stage destination number |
| wb_wr | input | 1 | Writeback-stage register-write flag |
| mem_alu_val | input | DATA_W | Memory-stage ALU result |
| wb_val | input | DATA_W | Writeback-stage result |
| id_rf_a | input | DATA_W | Register-file data for decode rs |
| id_rf_b | input | DATA_W | Register-file data for decode rt |
| ex_rf_a | input | DATA_W | Register-file data for execute rs |
| ex_rf_b | input | DATA_W | Register-file data for execute rt |
| ex_sel_a | output | 2 | Execute operand A select |
| ex_sel_b | output | 2 | Execute operand B select |
| id_sel_a | output | 1 | Decode operand A select |
| id_sel_b | output | 1 | Decode operand B select |
| ex_opnd_a | output | DATA_W | Selected execute operand A |
| ex_opnd_b | output | DATA_W | Selected execute operand B |
| id_opnd_a | output | DATA_W | Selected decode operand A |
| id_opnd_b | output | DATA_W | Selected decode operand B |

## Verification
The bench builds the block with REG_AW = 3 and DATA_W = 8, and keeps the muxes enabled. With eight register numbers, it walks every combination of the two execute sources, both destinations and both write flags. The decode sources take the execute sources in swapped order. Every match, non-match, priority collision and zero-register case is therefore applied. The bench gives the four data inputs distinct constants, so any wrong mux choice shows up directly in the operand values.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
   localparam int EX_SEL_W = 2;

   typedef enum logic [EX_SEL_W-1:0] {
      EXSRC_RF  = 2'b00,
      EXSRC_WB  = 2'b01,
      EXSRC_MEM = 2'b10
   } ex_src_e;

   localparam logic ID_SRC_RF  = 1'b0;
   localparam logic ID_SRC_MEM = 1'b1;
endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          wr,
   output logic          hit
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   always_comb begin
      hit = wr && (src == dst) && (src != ZERO_REG);
   end
endmodule

// File: rtl/bypass_ex_select.sv
module bypass_ex_select
   import bypass_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0]       src,
   input  logic [AW-1:0]       mem_dst,
   input  logic                mem_wr,
   input  logic [AW-1:0]       wb_dst,
   input  logic                wb_wr,
   output logic [EX_SEL_W-1:0] sel
);
   logic    mem_hit, wb_hit;
   ex_src_e choice;

   bypass_match #(.AW(AW)) u_mem (.src(src), .dst(mem_dst), .wr(mem_wr), .hit(mem_hit));
   bypass_match #(.AW(AW)) u_wb  (.src(src), .dst(wb_dst),  .wr(wb_wr),  .hit(wb_hit));

   always_comb begin
      if (mem_hit)     choice = EXSRC_MEM;
      else if (wb_hit) choice = EXSRC_WB;
      else             choice = EXSRC_RF;
      sel = choice;
   end

   always_comb begin
      if (mem_hit && wb_hit)
         assert_mem_wins_R2: assert (sel == EXSRC_MEM)
            else $error("memory stage lost priority");
      if (src == '0)
         assert_zero_src_R4: assert (sel == EXSRC_RF)
            else $error("zero register bypassed");
      if (!mem_wr && !wb_wr)
         assert_no_writer_R3: assert (sel == EXSRC_RF)
            else $error("bypass without writer");
   end
endmodule

// File: rtl/bypass_id_select.sv
module bypass_id_select
   import bypass_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] mem_dst,
   input  logic          mem_wr,
   output logic          sel
);
   logic mem_hit;

   bypass_match #(.AW(AW)) u_mem (.src(src), .dst(mem_dst), .wr(mem_wr), .hit(mem_hit));

   always_comb begin
      sel = mem_hit ? ID_SRC_MEM : ID_SRC_RF;
   end

   always_comb begin
      if (!mem_wr || src != mem_dst)
         assert_id_needs_mem_R7: assert (sel == ID_SRC_RF)
            else $error("decode bypass without memory match");
   end
endmodule

// File: rtl/bypass_operand_mux.sv
module bypass_operand_mux #(
   parameter int DW    = 32,
   parameter int NSRC  = 3,
   parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0][DW-1:0] cand,
   input  logic [SEL_W-1:0]        sel,
   output logic [DW-1:0]           out
);
   always_comb begin
      out = cand[0];
      for (int i = 1; i < NSRC; i++) begin
         if (sel == SEL_W'(i)) out = cand[i];
      end
   end

   always_comb begin
      if (sel == '0)
         assert_rf_pass_R8: assert (out == cand[0])
            else $error("register-file value not passed");
   end
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
   import bypass_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter int DATA_W = 32,
   parameter bit MUX_EN = 1'b1
) (
   input  logic [REG_AW-1:0]   id_src_a,
   input  logic [REG_AW-1:0]   id_src_b,
   input  logic [REG_AW-1:0]   ex_src_a,
   input  logic [REG_AW-1:0]   ex_src_b,
   input  logic [REG_AW-1:0]   mem_dst,
   input  logic                mem_wr,
   input  logic [REG_AW-1:0]   wb_dst,
   input  logic                wb_wr,
   input  logic [DATA_W-1:0]   mem_alu_val,
   input  logic [DATA_W-1:0]   wb_val,
   input  logic [DATA_W-1:0]   id_rf_a,
   input  logic [DATA_W-1:0]   id_rf_b,
   input  logic [DATA_W-1:0]   ex_rf_a,
   input  logic [DATA_W-1:0]   ex_rf_b,
   output logic [EX_SEL_W-1:0] ex_sel_a,
   output logic [EX_SEL_W-1:0] ex_sel_b,
   output logic                id_sel_a,
   output logic                id_sel_b,
   output logic [DATA_W-1:0]   ex_opnd_a,
   output logic [DATA_W-1:0]   ex_opnd_b,
   output logic [DATA_W-1:0]   id_opnd_a,
   output logic [DATA_W-1:0]   id_opnd_b
);
   localparam int NOPS   = 2;
   localparam int EX_SRC = 3;
   localparam int ID_SRC = 2;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("REG_AW out of range 1..8");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic [NOPS-1:0][REG_AW-1:0]   ex_src, id_src;
   logic [NOPS-1:0][DATA_W-1:0]   ex_rf, id_rf, ex_out, id_out;
   logic [NOPS-1:0][EX_SEL_W-1:0] ex_sel;
   logic [NOPS-1:0]               id_sel;

   assign ex_src = {ex_src_b, ex_src_a};
   assign id_src = {id_src_b, id_src_a};
   assign ex_rf  = {ex_rf_b, ex_rf_a};
   assign id_rf  = {id_rf_b, id_rf_a};

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      bypass_ex_select #(.AW(REG_AW)) u_exsel (
         .src(ex_src[k]), .mem_dst(mem_dst), .mem_wr(mem_wr),
         .wb_dst(wb_dst), .wb_wr(wb_wr), .sel(ex_sel[k])
      );
      bypass_id_select #(.AW(REG_AW)) u_idsel (
         .src(id_src[k]), .mem_dst(mem_dst), .mem_wr(mem_wr), .sel(id_sel[k])
      );

      if (MUX_EN) begin : g_mux
         bypass_operand_mux #(.DW(DATA_W), .NSRC(EX_SRC), .SEL_W(EX_SEL_W)) u_exmux (
            .cand({mem_alu_val, wb_val, ex_rf[k]}), .sel(ex_sel[k]), .out(ex_out[k])
         );
         bypass_operand_mux #(.DW(DATA_W), .NSRC(ID_SRC), .SEL_W(1)) u_idmux (
            .cand({mem_alu_val, id_rf[k]}), .sel(id_sel[k]), .out(id_out[k])
         );
      end else begin : g_nomux
         assign ex_out[k] = '0;
         assign id_out[k] = '0;
      end
   end

   assign ex_sel_a  = ex_sel[0];
   assign ex_sel_b  = ex_sel[1];
   assign id_sel_a  = id_sel[0];
   assign id_sel_b  = id_sel[1];
   assign ex_opnd_a = ex_out[0];
   assign ex_opnd_b = ex_out[1];
   assign id_opnd_a = id_out[0];
   assign id_opnd_b = id_out[1];

   always_comb begin
      if (MUX_EN && ex_sel_a == EXSRC_MEM)
         assert_exa_mem_R1: assert (ex_opnd_a == mem_alu_val)
            else $error("execute A not memory value");
      if (MUX_EN && ex_sel_b == EXSRC_WB)
         assert_exb_wb_R5: assert (ex_opnd_b == wb_val)
            else $error("execute B not writeback value");
      if (MUX_EN && id_sel_a == ID_SRC_MEM)
         assert_ida_mem_R6: assert (id_opnd_a == mem_alu_val)
            else $error("decode A not memory value");
      if (ex_src_a == ex_src_b)
         assert_same_src_R5: assert (ex_sel_a == ex_sel_b)
            else $error("operands disagree on identical source");
   end
endmodule

// File: tb/operand_bypass_unit_bench.sv
module operand_bypass_unit_bench;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int NR = 1 << AW;

   localparam logic [DW-1:0] V_MEM = 8'hA5, V_WB = 8'h3C;
   localparam logic [DW-1:0] V_IDA = 8'h11, V_IDB = 8'h22, V_EXA = 8'h33, V_EXB = 8'h44;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, mem_dst, wb_dst;
   logic          mem_wr, wb_wr;
   logic [1:0]    ex_sel_a, ex_sel_b;
   logic          id_sel_a, id_sel_b;
   logic [DW-1:0] ex_opnd_a, ex_opnd_b, id_opnd_a, id_opnd_b;

   int vectors = 0;
   int errors  = 0;

   operand_bypass_unit #(.REG_AW(AW), .DATA_W(DW), .MUX_EN(1'b1)) u_operand_bypass_unit (
      .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
      .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
      .mem_alu_val(V_MEM), .wb_val(V_WB),
      .id_rf_a(V_IDA), .id_rf_b(V_IDB), .ex_rf_a(V_EXA), .ex_rf_b(V_EXB),
      .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .id_sel_a(id_sel_a), .id_sel_b(id_sel_b),
      .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b), .id_opnd_a(id_opnd_a), .id_opnd_b(id_opnd_b)
   );

   function automatic logic [1:0] exp_ex(input logic [AW-1:0] s);
      if (s != 0 && mem_wr && mem_dst == s) return 2'b10;
      if (s != 0 && wb_wr && wb_dst == s)   return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic exp_id(input logic [AW-1:0] s);
      return (s != 0 && mem_wr && mem_dst == s);
   endfunction

   function automatic logic [DW-1:0] ex_val(input logic [1:0] c, input logic [DW-1:0] rf);
      return (c == 2'b10) ? V_MEM : (c == 2'b01) ? V_WB : rf;
   endfunction

   task automatic cmp(input string what, input string tags, input int act, input int exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s] actual=%0h expected=%0h (rs=%0d rt=%0d md=%0d mw=%0b wd=%0d ww=%0b)",
                  what, tags, act, exp, ex_src_a, ex_src_b, mem_dst, mem_wr, wb_dst, wb_wr);
      end
   endtask

   task automatic check_all();
      logic [1:0] ea, eb;
      logic       ia, ib;
      ea = exp_ex(ex_src_a);
      eb = exp_ex(ex_src_b);
      ia = exp_id(id_src_a);
      ib = exp_id(id_src_b);
      vectors++;
      cmp("ex_sel_a", "R1 R2 R3 R4", ex_sel_a, ea);
      cmp("ex_sel_b", "R5 R1 R2 R3 R4", ex_sel_b, eb);
      cmp("id_sel_a", "R6 R7 R4", id_sel_a, ia);
      cmp("id_sel_b", "R6 R7 R5", id_sel_b, ib);
      cmp("ex_opnd_a", "R8", ex_opnd_a, ex_val(ea, V_EXA));
      cmp("ex_opnd_b", "R8", ex_opnd_b, ex_val(eb, V_EXB));
      cmp("id_opnd_a", "R8", id_opnd_a, ia ? V_MEM : V_IDA);
      cmp("id_opnd_b", "R8", id_opnd_b, ib ? V_MEM : V_IDB);
   endtask

   task automatic apply(input int a, input int b, input int md, input int wd,
                        input logic mw, input logic ww);
      @(posedge clk);
      #1;
      ex_src_a = AW'(a);
      ex_src_b = AW'(b);
      id_src_a = AW'(b);
      id_src_b = AW'(a);
      mem_dst  = AW'(md);
      wb_dst   = AW'(wd);
      mem_wr   = mw;
      wb_wr    = ww;
      @(negedge clk);
      check_all();
   endtask

   initial begin
      // idle state: all zero inputs give register-file selects (R4)
      apply(0, 0, 0, 0, 1'b0, 1'b0);
      // directed priority collision (R2) and writeback-only decode case (R7)
      apply(5, 3, 5, 5, 1'b1, 1'b1);
      apply(5, 3, 2, 5, 1'b1, 1'b1);
      apply(0, 0, 0, 0, 1'b1, 1'b1);
      // full sweep
      for (int f = 0; f < 4; f++)
         for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++)
               for (int md = 0; md < NR; md++)
                  for (int wd = 0; wd < NR; wd++)
                     apply(a, b, md, wd, f[1], f[0]);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog [R1] actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule